// File: doc/BRIEF.md
# DisplayPort Transmitter Bring-Up Sequencer

This block runs the start-up handshake of a display transmitter whose link is managed by a separate controller running its own firmware. When asked to start, it reads a transmitter-type status field. On a normal start it reads the field once. When the system is returning from a sleep state, it keeps reading the field at a fixed interval for up to a bounded number of attempts. A transmitter reported as firmware-managed then has its coprocessor-launch status polled for a limited number of intervals. The outcome sets a sticky capability flag on success. It also sets a sticky host-read-done control flag whenever the firmware-managed type was seen.

The same sequencer serves two other commands. The video-enable command writes the enable control bit at once. When the link is trained and a sink is plugged in, it then holds until the mirrored enable status echoes the request. The power command drives the PHY sleep control bit and leaves video enable alone. Poll intervals are counted in clock cycles and set by parameters. One `done` pulse marks the end of each command, and `busy` covers every multi-cycle command.

Top module: `dptx_bringup_seq`

## Requirements
- R1: After reset, busy, done, ready, cap_flag, host_done, phy_sleep and video_en are all 0.
- R2: A start command reads tx_type once when resume is 0, and up to RESUME_TRIES times when resume is 1, with POLL_TICKS cycles between reads. It stops at the first nonzero value. If every read is zero, it finishes with ready 0 after a final POLL_TICKS wait.
- R3: Only the type code 4'hE continues to the launch check. Any other nonzero code finishes at once with ready 0 and leaves cap_flag and host_done unchanged.
- R4: After code 4'hE, launch_ok is read up to LAUNCH_TRIES times, POLL_TICKS cycles apart. If none of the reads is 1, the command finishes with ready 0 after the last wait.
- R5: cap_flag is set only when launch_ok was seen. host_done is set whenever code 4'hE was seen, whatever the launch outcome. Both flags stay set until reset.
- R6: A video command writes video_val to video_en in the accepting cycle. If link_ok and hpd are both 1, it stays busy until bit 4 of mirror_stat equals video_val. The bit is checked at once and then every STEP_TICKS cycles. No other bit of mirror_stat matters.
- R7: A video command accepted while link_ok or hpd is 0 completes in the accepting cycle.
- R8: A power command with power_on 0 sets phy_sleep to 1, and one with power_on 1 clears it. video_en keeps its value in both cases.
- R9: busy is 1 while a start or video command is in progress, and every request arriving then is ignored. When requests arrive together at idle, start wins over video, and video wins over power.
- R10: done is a one-cycle pulse at the end of each command. ready holds the result of the most recent start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start the bring-up sequence |
| resume | input | 1 | Start is a return from sleep (long detection window) |
| tx_type | input | TYPE_W | Transmitter-type status field |
| launch_ok | input | 1 | Coprocessor reports launch |
| video_req | input | 1 | Video enable/disable command |
| video_val | input | 1 | Requested video enable value |
| link_ok | input | 1 | Link trained status |
| hpd | input | 1 | Hot-plug status |
| mirror_stat | input | 8 | Status byte, bit 4 mirrors applied video enable |
| power_req | input | 1 | Power command |
| power_on | input | 1 | 1 = wake PHY, 0 = put PHY to sleep |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Result of the last start command |
| cap_flag | output | 1 | Sticky: firmware-managed transmitter is running |
| host_done | output | 1 | Sticky host-read-done control flag |
| video_en | output | 1 | Video enable control bit |
| phy_sleep | output | 1 | PHY sleep control bit |

## Verification
The bench times the two long timeouts exactly: the full resume window with no type ever reported, and ten failed launch reads. A design that miscounts attempts, or that skips the wait after the last read, finishes a whole interval early or late. It also checks that a failed launch still sets host_done while cap_flag stays clear, which catches a design that ties the two flags together. In the video wait it sets every mirror bit except bit 4 and sends a power request during the wait. A design that compares the whole byte would hang, and one that accepts commands while busy would toggle phy_sleep. Power commands are made with video enabled, so a design that rewrites the whole control byte shows up as a lost video_en.

// File: rtl/dptx_seq_pkg.sv
package dptx_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DET_CHK,
        SQ_DET_WAIT,
        SQ_LCH_CHK,
        SQ_LCH_WAIT,
        SQ_VID_CHK,
        SQ_VID_WAIT
    } seq_state_t;

    localparam logic [3:0] FW_TX_CODE = 4'hE;
    localparam int         MIRROR_BIT = 4;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dptx_tick_timer.sv
module dptx_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= len - W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - W'(1);
        end
    end

    assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/dptx_try_counter.sv
module dptx_try_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + W'(1);
    end

    assign hit = (cnt_q == limit);
endmodule

// File: rtl/dptx_bringup_seq.sv
module dptx_bringup_seq
    import dptx_seq_pkg::*;
#(
    parameter int POLL_TICKS   = 100,
    parameter int STEP_TICKS   = 10,
    parameter int RESUME_TRIES = 300,
    parameter int LAUNCH_TRIES = 10,
    parameter int TYPE_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              resume,
    input  logic [TYPE_W-1:0] tx_type,
    input  logic              launch_ok,
    input  logic              video_req,
    input  logic              video_val,
    input  logic              link_ok,
    input  logic              hpd,
    input  logic [7:0]        mirror_stat,
    input  logic              power_req,
    input  logic              power_on,
    output logic              busy,
    output logic              done,
    output logic              ready,
    output logic              cap_flag,
    output logic              host_done,
    output logic              video_en,
    output logic              phy_sleep
);
    localparam int TMR_W = $clog2(max_int(POLL_TICKS, STEP_TICKS) + 1);
    localparam int TRY_W = $clog2(max_int(RESUME_TRIES, LAUNCH_TRIES) + 1);

    seq_state_t       state_q;
    logic [TRY_W-1:0] lim_q;
    logic             vid_q;
    logic             done_q, ready_q, cap_q, host_q, ven_q, sleep_q;

    logic             type_zero, type_fw, mirror_match;
    logic             arm_poll, arm_step, tmr_arm, tmr_exp;
    logic [TMR_W-1:0] tmr_len;
    logic             try_clr, try_hit;

    assign type_zero    = (tx_type == '0);
    assign type_fw      = (tx_type == TYPE_W'(FW_TX_CODE));
    assign mirror_match = (mirror_stat[MIRROR_BIT] == vid_q);

    always_comb begin
        arm_poll = ((state_q == SQ_DET_CHK) && type_zero) ||
                   ((state_q == SQ_LCH_CHK) && !launch_ok);
        arm_step = (state_q == SQ_VID_CHK) && !mirror_match;
        tmr_arm  = arm_poll || arm_step;
        tmr_len  = arm_step ? TMR_W'(STEP_TICKS) : TMR_W'(POLL_TICKS);
        try_clr  = (state_q == SQ_IDLE) || ((state_q == SQ_DET_CHK) && type_fw);
    end

    dptx_tick_timer #(.W(TMR_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (tmr_arm),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    dptx_try_counter #(.W(TRY_W)) i_tries (
        .clk   (clk),
        .rst   (rst),
        .clr   (try_clr),
        .inc   (arm_poll),
        .limit (lim_q),
        .hit   (try_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            lim_q   <= '0;
            vid_q   <= 1'b0;
            done_q  <= 1'b0;
            ready_q <= 1'b0;
            cap_q   <= 1'b0;
            host_q  <= 1'b0;
            ven_q   <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_req) begin
                        state_q <= SQ_DET_CHK;
                        lim_q   <= resume ? TRY_W'(RESUME_TRIES) : TRY_W'(1);
                    end else if (video_req) begin
                        ven_q <= video_val;
                        vid_q <= video_val;
                        if (link_ok && hpd) state_q <= SQ_VID_CHK;
                        else                done_q  <= 1'b1;
                    end else if (power_req) begin
                        sleep_q <= !power_on;
                        done_q  <= 1'b1;
                    end
                end
                SQ_DET_CHK: begin
                    if (type_zero) begin
                        state_q <= SQ_DET_WAIT;
                    end else if (type_fw) begin
                        state_q <= SQ_LCH_CHK;
                        lim_q   <= TRY_W'(LAUNCH_TRIES);
                    end else begin
                        state_q <= SQ_IDLE;
                        ready_q <= 1'b0;
                        done_q  <= 1'b1;
                    end
                end
                SQ_DET_WAIT: begin
                    if (tmr_exp) begin
                        if (try_hit) begin
                            state_q <= SQ_IDLE;
                            ready_q <= 1'b0;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SQ_DET_CHK;
                        end
                    end
                end
                SQ_LCH_CHK: begin
                    if (launch_ok) begin
                        state_q <= SQ_IDLE;
                        cap_q   <= 1'b1;
                        host_q  <= 1'b1;
                        ready_q <= 1'b1;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= SQ_LCH_WAIT;
                    end
                end
                SQ_LCH_WAIT: begin
                    if (tmr_exp) begin
                        if (try_hit) begin
                            state_q <= SQ_IDLE;
                            host_q  <= 1'b1;
                            ready_q <= 1'b0;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SQ_LCH_CHK;
                        end
                    end
                end
                SQ_VID_CHK: begin
                    if (mirror_match) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= SQ_VID_WAIT;
                    end
                end
                SQ_VID_WAIT: begin
                    if (tmr_exp) state_q <= SQ_VID_CHK;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != SQ_IDLE);
    assign done      = done_q;
    assign ready     = ready_q;
    assign cap_flag  = cap_q;
    assign host_done = host_q;
    assign video_en  = ven_q;
    assign phy_sleep = sleep_q;
endmodule

// File: rtl/dptx_seq_checker.sv
module dptx_seq_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic ready,
    input logic cap_flag,
    input logic host_done,
    input logic video_en,
    input logic phy_sleep
);
    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (rst)
        cap_flag |=> cap_flag);                                   // R5
    AST_HOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        host_done |=> host_done);                                 // R5
    AST_CAP_NEEDS_HOST: assert property (@(posedge clk) disable iff (rst)
        cap_flag |-> host_done);                                  // R5
    AST_CAP_RISE_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_flag) |-> (ready && done));                     // R10
    AST_SLEEP_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(phy_sleep));                             // R9
    AST_VIDEO_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(video_en));                              // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                          // R10
endmodule

bind dptx_bringup_seq dptx_seq_checker i_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .ready     (ready),
    .cap_flag  (cap_flag),
    .host_done (host_done),
    .video_en  (video_en),
    .phy_sleep (phy_sleep)
);

// File: tb/test_dptx_bringup_seq.sv
module test_dptx_bringup_seq;
    localparam int P    = 20;
    localparam int S    = 5;
    localparam int RT   = 300;
    localparam int LT   = 10;
    localparam int TOL  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 0, resume = 0, launch_ok = 0;
    logic [3:0] tx_type = 4'h0;
    logic       video_req = 0, video_val = 0, link_ok = 0, hpd = 0;
    logic [7:0] mirror_stat = 8'h00;
    logic       power_req = 0, power_on = 0;
    logic       busy, done, ready, cap_flag, host_done, video_en, phy_sleep;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dptx_bringup_seq #(
        .POLL_TICKS(P), .STEP_TICKS(S), .RESUME_TRIES(RT),
        .LAUNCH_TRIES(LT), .TYPE_W(4)
    ) i_dptx_bringup_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .resume(resume),
        .tx_type(tx_type), .launch_ok(launch_ok), .video_req(video_req),
        .video_val(video_val), .link_ok(link_ok), .hpd(hpd),
        .mirror_stat(mirror_stat), .power_req(power_req), .power_on(power_on),
        .busy(busy), .done(done), .ready(ready), .cap_flag(cap_flag),
        .host_done(host_done), .video_en(video_en), .phy_sleep(phy_sleep)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        checks++;
        if (act < exp - TOL || act > exp + TOL) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse a request on one edge; returns sampled just after that edge.
    task automatic pulse_start(input logic res);
        @(negedge clk); start_req = 1; resume = res;
        @(posedge clk); #1; start_req = 0;
    endtask

    // Counts edges after the accepting edge until done is seen.
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk); #1; cyc++;
        end
        if (!done) check("R10 done timeout", 0, 1);
        else begin
            @(posedge clk); #1;
            check("R10 done one cycle", done, 0);
        end
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 ready", ready, 0);
        check("R1 cap_flag", cap_flag, 0);
        check("R1 host_done", host_done, 0);
        check("R1 phy_sleep", phy_sleep, 0);
        check("R1 video_en", video_en, 0);
    endtask

    task automatic t_other_type;
        int c;
        tx_type = 4'h3;
        pulse_start(0);
        check("R9 busy during start", busy, 1);
        wait_done(c);
        check("R3 other type quick", c, 1);
        check("R3 ready", ready, 0);
        check("R3 host_done unchanged", host_done, 0);
        check("R3 cap_flag unchanged", cap_flag, 0);
    endtask

    task automatic t_notype_normal;
        int c;
        tx_type = 4'h0;
        pulse_start(0);
        wait_done(c);
        check_near("R2 single read window", c, P + 1);
        check("R2 ready", ready, 0);
    endtask

    task automatic t_launch_fail;
        int c;
        tx_type = 4'hE; launch_ok = 0;
        pulse_start(0);
        wait_done(c);
        check_near("R4 launch timeout", c, LT * P + LT + 1);
        check("R4 ready", ready, 0);
        check("R5 host_done on fail", host_done, 1);
        check("R5 cap_flag on fail", cap_flag, 0);
    endtask

    task automatic t_resume_late;
        int c;
        tx_type = 4'h0; launch_ok = 0;
        pulse_start(1);
        repeat (3 * P) @(posedge clk);
        #1;
        check("R2 still polling on resume", busy, 1);
        @(negedge clk); tx_type = 4'hE; launch_ok = 1;
        wait_done(c);
        check("R5 cap_flag on success", cap_flag, 1);
        check("R10 ready success", ready, 1);
    endtask

    task automatic t_resume_never;
        int c;
        tx_type = 4'h0; launch_ok = 0;
        pulse_start(1);
        wait_done(c);
        check_near("R2 resume window", c, RT * P + RT);
        check("R10 ready after failed start", ready, 0);
        check("R5 cap_flag sticky", cap_flag, 1);
    endtask

    task automatic t_video_linkdown(input logic v);
        link_ok = 0; hpd = 1;
        @(negedge clk); video_req = 1; video_val = v;
        @(posedge clk); #1; video_req = 0;
        check("R7 immediate done", done, 1);
        check("R7 busy", busy, 0);
        check("R6 video_en written", video_en, v);
    endtask

    task automatic t_video_wait;
        int c;
        link_ok = 1; hpd = 1; mirror_stat = 8'h10;
        @(negedge clk); video_req = 1; video_val = 0;
        @(posedge clk); #1; video_req = 0;
        check("R6 video_en written at once", video_en, 0);
        repeat (3 * S) @(posedge clk);
        #1;
        check("R6 waiting for mirror", busy, 1);
        @(negedge clk); power_req = 1; power_on = 0;
        @(posedge clk); #1; power_req = 0;
        check("R9 power ignored while busy", phy_sleep, 0);
        @(negedge clk); mirror_stat = 8'hEF;
        wait_done(c);
        check("R6 completes within a step", (c <= S + 2) ? 1 : 0, 1);
        check("R9 phy_sleep after busy", phy_sleep, 0);
    endtask

    task automatic t_power;
        int c;
        @(negedge clk); power_req = 1; power_on = 0;
        @(posedge clk); #1; power_req = 0;
        check("R8 sleep set", phy_sleep, 1);
        check("R8 video_en kept", video_en, 1);
        check("R10 power done", done, 1);
        @(negedge clk); power_req = 1; power_on = 1;
        @(posedge clk); #1; power_req = 0;
        check("R8 sleep cleared", phy_sleep, 0);
        check("R8 video_en kept on wake", video_en, 1);
        // priority: start with power together
        tx_type = 4'h3;
        @(negedge clk); start_req = 1; resume = 0; power_req = 1; power_on = 0;
        @(posedge clk); #1; start_req = 0; power_req = 0;
        check("R9 start wins", busy, 1);
        wait_done(c);
        check("R9 power dropped", phy_sleep, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        t_reset();
        t_other_type();
        t_notype_normal();
        t_launch_fail();
        t_resume_late();
        t_resume_never();
        t_video_linkdown(1'b1);
        t_video_wait();
        t_video_linkdown(1'b1);
        t_power();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule